// File: doc/BRIEF.md
# Float-to-Unsigned Truncating Converter

This unit takes an IEEE-754 single-precision operand and returns a 32-bit unsigned integer. Any fractional part is discarded, so rounding is always toward zero. Two exception flags come with each result. The invalid flag reports an operand that has no unsigned value: a NaN, anything strictly below zero, or anything at or above 2^32. The inexact flag reports that nonzero fraction bits were dropped. A pair of status strobes tells the surrounding logic what to do with its floating-point status. One strobe merges the flags into the sticky bits. The other clears the summary bit when the conversion was clean.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, through a single output register. A new operand is accepted when the output register is empty or is being drained in the same cycle. While the consumer holds `out_ready` low, the held result and its flags and strobes stay frozen, and `in_ready` stays low. When invalid is raised, inexact is always withheld. Negative zero counts as zero and is not treated as a negative input.

Top module: `f2u_trunc_conv`

## Requirements
- R1: A positive finite operand below 2^32 yields its integer part, and an exactly integral value raises neither flag.
- R2: A positive in-range operand with nonzero dropped fraction bits raises inexact only. This includes values in (0, 1), which yield 0.
- R3: Every NaN (quiet or signalling, either sign) yields result 0 with invalid raised.
- R4: Whenever invalid is raised, inexact is reported as 0.
- R5: An operand strictly below zero yields 0 with invalid only. This covers negative normals, negative subnormals such as 0x80000001, fractions such as -0.5, and negative infinity.
- R6: Positive zero (0x00000000) and negative zero (0x80000000) yield 0 with no flags.
- R7: A positive operand whose integer part is 2^32 or more, and positive infinity, yield 0xFFFFFFFF with invalid only. The largest value that still converts is 0x4F7FFFFF, which gives 0xFFFFFF00 with no flags.
- R8: A positive subnormal yields 0 with inexact raised.
- R9: With each valid result, exactly one strobe is high. `out_stat_set` is high when either flag is raised, and `out_stat_clr` is high when neither is. Both strobes are low when no result is valid.
- R10: An operand accepted at a clock edge (`in_valid` and `in_ready` both high) appears at the output after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output holds stable.
- R11: While `rst_n` is low, `out_valid`, `out_stat_set` and `out_stat_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_op | input | 32 | Single-precision operand (bit 31 sign, 30:23 exponent, 22:0 fraction) |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Unsigned truncated integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_stat_set | output | 1 | Merge the flags into the sticky status |
| out_stat_clr | output | 1 | Clear the status summary bit |

## Verification
The hardest cases to reach are those at the edges of the number line: the boundary between exponents 158 and 159, where the result changes from a full left-shifted significand to saturation, and subnormals with the sign set, which must be flagged invalid while negative zero must not. Uniform random operands land almost entirely in saturation or in the zero region. The stimulus therefore weights exponent choices: it draws often from the band near the binary point, from exponent 0, and from exponents 158 and 159, with sign and fraction chosen at random. A directed list covers each special encoding, and a separate sequence with the consumer stalled checks the hold behaviour.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_NORM,
    CLS_SUBN,
    CLS_INF,
    CLS_NAN
  } f2u_cls_e;

  typedef struct packed {
    logic inv;
    logic inx;
  } f2u_flags_t;

endpackage

// File: rtl/f2u_classify.sv
module f2u_classify
  import f2u_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] man_i,
  output f2u_cls_e      cls_o
);

  logic exp_max;
  logic exp_min;
  logic man_nz;

  assign exp_max = &exp_i;
  assign exp_min = ~|exp_i;
  assign man_nz  = |man_i;

  always_comb begin
    if (exp_max)      cls_o = man_nz ? CLS_NAN : CLS_INF;
    else if (exp_min) cls_o = man_nz ? CLS_SUBN : CLS_ZERO;
    else              cls_o = CLS_NORM;
  end

endmodule

// File: rtl/f2u_magnitude.sv
module f2u_magnitude #(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int IW = 32
) (
  input  logic [EW-1:0] exp_i,
  input  logic [MW-1:0] man_i,
  output logic [IW-1:0] mag_o,
  output logic          lost_o,
  output logic          ovf_o
);

  localparam int SIG_W = MW + 1;
  localparam int BIAS  = (1 << (EW - 1)) - 1;
  localparam int SH_W  = $clog2(SIG_W + 1);
  localparam logic [EW:0] POINT_E = (EW + 1)'(BIAS + MW);
  localparam logic [EW:0] OVF_E   = (EW + 1)'(BIAS + IW);
  localparam logic [EW:0] SIG_LIM = (EW + 1)'(SIG_W);

  logic [SIG_W-1:0] sig;
  logic [EW:0]      e_ext;
  logic [EW:0]      lsh;
  logic [EW:0]      rsh_full;
  logic [SH_W-1:0]  amt;
  logic [IW-1:0]    mag_l;
  logic [IW-1:0]    mag_r;

  // subnormals share the scale of exponent 1 without the hidden bit
  assign sig   = {(|exp_i), man_i};
  assign e_ext = (|exp_i) ? {1'b0, exp_i} : (EW + 1)'(1);

  assign lsh   = e_ext - POINT_E;
  assign mag_l = {{(IW - SIG_W){1'b0}}, sig} << lsh;

  assign rsh_full = POINT_E - e_ext;
  assign amt = (rsh_full >= SIG_LIM) ? SH_W'(SIG_W) : rsh_full[SH_W-1:0];

  // staged right shifter collecting discarded bits per stage
  logic [SIG_W-1:0] stg [SH_W+1];
  logic             stk [SH_W+1];

  assign stg[0] = sig;
  assign stk[0] = 1'b0;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_rsh
      assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
      assign stk[k+1] = stk[k] | (amt[k] & (|stg[k][(1 << k) - 1:0]));
    end
  endgenerate

  assign mag_r = {{(IW - SIG_W){1'b0}}, stg[SH_W]};

  always_comb begin
    ovf_o  = 1'b0;
    lost_o = 1'b0;
    mag_o  = '0;
    if (e_ext >= OVF_E) begin
      ovf_o = 1'b1;
    end else if (e_ext >= POINT_E) begin
      mag_o = mag_l;
    end else begin
      mag_o  = mag_r;
      lost_o = stk[SH_W];
    end
  end

endmodule

// File: rtl/f2u_select.sv
module f2u_select
  import f2u_pkg::*;
#(
  parameter int IW = 32
) (
  input  f2u_cls_e      cls_i,
  input  logic          sign_i,
  input  logic [IW-1:0] mag_i,
  input  logic          lost_i,
  input  logic          ovf_i,
  output logic [IW-1:0] res_o,
  output f2u_flags_t    flg_o
);

  always_comb begin
    res_o = '0;
    flg_o = '{inv: 1'b0, inx: 1'b0};
    unique case (cls_i)
      CLS_NAN: begin
        flg_o.inv = 1'b1;
      end
      CLS_INF: begin
        flg_o.inv = 1'b1;
        res_o     = sign_i ? '0 : '1;
      end
      CLS_ZERO: begin
        res_o = '0;
      end
      default: begin
        if (sign_i) begin
          // strictly negative: invalid only, inexact withheld
          flg_o.inv = 1'b1;
        end else if (ovf_i) begin
          flg_o.inv = 1'b1;
          res_o     = '1;
        end else begin
          res_o     = mag_i;
          flg_o.inx = lost_i;
        end
      end
    endcase
  end

endmodule

// File: rtl/f2u_trunc_conv.sv
module f2u_trunc_conv
  import f2u_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int IW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [EW+MW:0]      in_op,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [IW-1:0]       out_result,
  output logic                out_invalid,
  output logic                out_inexact,
  output logic                out_stat_set,
  output logic                out_stat_clr
);

  localparam int FW = 1 + EW + MW;

  logic          op_sign;
  logic [EW-1:0] op_exp;
  logic [MW-1:0] op_man;
  f2u_cls_e      cls;
  logic [IW-1:0] mag;
  logic          lost;
  logic          ovf;
  logic [IW-1:0] res_c;
  f2u_flags_t    flg_c;
  logic          take;

  assign op_sign = in_op[FW-1];
  assign op_exp  = in_op[FW-2:MW];
  assign op_man  = in_op[MW-1:0];

  f2u_classify #(.EW(EW), .MW(MW)) u_cls (
    .exp_i (op_exp),
    .man_i (op_man),
    .cls_o (cls)
  );

  f2u_magnitude #(.EW(EW), .MW(MW), .IW(IW)) u_mag (
    .exp_i  (op_exp),
    .man_i  (op_man),
    .mag_o  (mag),
    .lost_o (lost),
    .ovf_o  (ovf)
  );

  f2u_select #(.IW(IW)) u_sel (
    .cls_i  (cls),
    .sign_i (op_sign),
    .mag_i  (mag),
    .lost_i (lost),
    .ovf_i  (ovf),
    .res_o  (res_c),
    .flg_o  (flg_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_inexact  <= 1'b0;
      out_stat_set <= 1'b0;
      out_stat_clr <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_result   <= res_c;
      out_invalid  <= flg_c.inv;
      out_inexact  <= flg_c.inx;
      out_stat_set <= flg_c.inv | flg_c.inx;
      out_stat_clr <= ~(flg_c.inv | flg_c.inx);
    end else if (out_ready) begin
      out_valid    <= 1'b0;
      out_stat_set <= 1'b0;
      out_stat_clr <= 1'b0;
    end
  end

  // R4
  inv_hides_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  // R7
  inv_extreme_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_result == '0 || out_result == '1));

  // R9
  stat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({out_stat_set, out_stat_clr}));

  // R9
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_stat_set && !out_stat_clr));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_invalid)));

  // R10
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

endmodule

// File: tb/tb_f2u_trunc_conv.sv
module tb_f2u_trunc_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_stat_set;
  logic        out_stat_clr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  f2u_trunc_conv dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_invalid(out_invalid), .out_inexact(out_inexact),
    .out_stat_set(out_stat_set), .out_stat_clr(out_stat_clr)
  );

  // expected {result, invalid, inexact, set, clr}
  function automatic logic [35:0] model(input logic [31:0] op);
    logic        s = op[31];
    logic [7:0]  e = op[30:23];
    logic [22:0] m = op[22:0];
    logic [63:0] sig;
    logic [31:0] r = 0;
    logic        inv = 0;
    logic        inx = 0;
    int          ex;
    if (e == 8'hFF) begin
      inv = 1;
      r = (m == 0 && !s) ? 32'hFFFFFFFF : 32'h0;
    end else if (e == 0 && m == 0) begin
      r = 0;
    end else if (s) begin
      inv = 1;
    end else begin
      sig = {41'd0, (e != 0), m};
      ex = ((e == 0) ? 1 : int'(e)) - 150;
      if (ex > 8) begin
        inv = 1; r = 32'hFFFFFFFF;
      end else if (ex >= 0) begin
        sig = sig << ex;
        if (sig[63:32] != 0) begin inv = 1; r = 32'hFFFFFFFF; end
        else r = sig[31:0];
      end else begin
        for (int i = 0; i < -ex; i++) begin
          if (sig[0]) inx = 1;
          sig = sig >> 1;
        end
        r = sig[31:0];
      end
    end
    return {r, inv, inx, (inv | inx), !(inv | inx)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] outs();
    return {out_result, out_invalid, out_inexact, out_stat_set, out_stat_clr};
  endfunction

  // called at a falling edge; checks the result one edge later
  task automatic apply(input logic [31:0] op, input string tag);
    logic [35:0] e;
    e = model(op);
    in_valid = 1'b1;
    in_op = op;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && outs() == e, tag, outs(), e);
  endtask

  function automatic logic [31:0] pick();
    int c = $urandom % 8;
    logic [31:0] v = $urandom;
    logic [7:0] e;
    case (c)
      0, 1, 2, 3, 4: begin
        e = 8'(110 + ($urandom % 61));
        v[30:23] = e;
        v[31] = (($urandom % 6) == 0);
      end
      5: ;
      6: v[30:23] = 8'd0;
      default: v[30:23] = (($urandom % 2) == 0) ? 8'd158 : 8'd159;
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20261));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !out_stat_set && !out_stat_clr, "R11",
        {33'd0, out_valid, out_stat_set, out_stat_clr}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R11", {34'd0, out_valid, in_ready}, 36'd1);

    apply(32'h00000000, "R6");
    apply(32'h80000000, "R6");
    apply(32'h3F800000, "R1");
    apply(32'h4B000001, "R1");
    apply(32'h4F000000, "R1");
    apply(32'h4F7FFFFF, "R7");
    apply(32'h3F7FFFFF, "R2");
    apply(32'h3F000000, "R2");
    apply(32'h3FC00000, "R2");
    apply(32'h3FFFFFFF, "R2");
    apply(32'h7FC00000, "R3");
    apply(32'h7F800001, "R3");
    apply(32'hFFC00001, "R3");
    apply(32'hBFC00000, "R4");
    apply(32'hBF000000, "R5");
    apply(32'h80000001, "R5");
    apply(32'hFF800000, "R5");
    apply(32'hC2F60000, "R5");
    apply(32'h7F800000, "R7");
    apply(32'h4F800000, "R7");
    apply(32'h7F7FFFFF, "R7");
    apply(32'h00000001, "R8");
    apply(32'h007FFFFF, "R8");
    apply(32'h3F800000, "R9");
    apply(32'h3F400000, "R9");

    for (int n = 0; n < 4000; n++) apply(pick(), "RND");

    // R10 back-pressure: drain, stall, then release
    @(negedge clk);
    chk(!out_valid && !out_stat_set && !out_stat_clr, "R9",
        {33'd0, out_valid, out_stat_set, out_stat_clr}, 36'd0);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_op = 32'h41200000;
    @(negedge clk);
    chk(out_valid && outs() == model(32'h41200000), "R10", outs(), model(32'h41200000));
    chk(!in_ready, "R10", {35'd0, in_ready}, 36'd0);
    in_op = 32'h40A00000;
    @(negedge clk);
    chk(out_valid && outs() == model(32'h41200000), "R10", outs(), model(32'h41200000));
    chk(!in_ready, "R10", {35'd0, in_ready}, 36'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && outs() == model(32'h40A00000), "R10", outs(), model(32'h40A00000));
    @(negedge clk);
    chk(!out_valid, "R10", {35'd0, out_valid}, 36'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule